// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This peripheral drives a configuration clock line with an exact, software-chosen number of pulses. Software writes a pulse count into the count register over a 32-bit memory-mapped bus. The block then toggles its clock output that many times and raises a busy output for the whole burst. When the last pulse has finished, it sets a sticky done flag in the status register.

Software clears the done flag by writing a one to it. A typical sequence is: clear the flag, write the count, then poll the status register until the flag reads back as one. A count write is acted on only while the block is idle. A count of zero completes at once, with no pulses.

The counter width is a parameter. The default width is enough for flush bursts of a few hundred pulses and for the 2047-pulse lead-in that comes before data streaming.

Top module: `cfg_pulse_burst`

## Requirements
- R1: After reset, `dclk` and `busy` are 0, the done flag is 0, and the count register reads 0.
- R2: The count register is at byte offset 0x08 and the status register is at byte offset 0x0C. Status bit 0 is the done flag, bit 1 is busy, and all other bits read 0. Read data appears on `bus_rdata` the cycle after the edge that samples `bus_rd`, and holds until the next read.
- R3: A count write of N > 0 while idle makes `busy` high from the cycle after the write, for exactly 2N cycles.
- R4: Each pulse is one cycle high followed by one cycle low. A burst gives exactly N rising edges of `dclk`, and `dclk` is never high while `busy` is low.
- R5: The done flag is 1 in the first cycle in which `busy` is low again after a burst. It then stays 1 until software clears it.
- R6: A write to the status register with bit 0 = 1 clears the done flag. A write with bit 0 = 0 leaves it unchanged.
- R7: A count write of zero while idle produces no pulse and keeps `busy` low. The done flag reads 1 from the cycle after the write.
- R8: A count write during a burst is ignored. The burst length and the value read back from the count register do not change.
- R9: Reads from offsets other than 0x08 and 0x0C return 0. Writes to those offsets change no state.
- R10: Only the low CNT_W bits (default 16) of a count write are used. A count of 0x7FF gives 2047 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| dclk | output | 1 | Configuration clock pulse output |
| busy | output | 1 | High while a burst is in progress |

## Verification
Results come due at fixed distances from a stimulus. `busy` and the first high phase of `dclk` appear in the cycle after the write edge. The burst ends 2N cycles later, and done becomes visible together with the fall of `busy`. Read data is due one cycle after the read strobe. The bench drives on the falling edge, and its monitor compares a queued read expectation exactly one falling edge after the sampling rising edge. Pulses and busy cycles are counted at the falling edges, so every count covers a whole burst and matches 2N and N exactly.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

    localparam int unsigned BUS_W = 32;

    // Byte offsets decoded by the register block
    localparam logic [BUS_W-1:0] OFS_COUNT  = 32'h0000_0008;
    localparam logic [BUS_W-1:0] OFS_STATUS = 32'h0000_000C;

    // Status word bit positions
    localparam int unsigned ST_DONE_BIT = 0;
    localparam int unsigned ST_BUSY_BIT = 1;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2
    } reg_sel_e;

    // Engine-visible state flags
    typedef struct packed {
        logic busy;
        logic level;
        logic done;
    } eng_flags_t;

    function automatic reg_sel_e decode_offset(input logic [BUS_W-1:0] ofs);
        if (ofs == OFS_COUNT)
            return SEL_COUNT;
        else if (ofs == OFS_STATUS)
            return SEL_STATUS;
        else
            return SEL_NONE;
    endfunction

    function automatic logic [BUS_W-1:0] status_word(input logic busy_f, input logic done_f);
        logic [BUS_W-1:0] w;
        w              = '0;
        w[ST_DONE_BIT] = done_f;
        w[ST_BUSY_BIT] = busy_f;
        return w;
    endfunction

endpackage

// File: rtl/cpb_regs.sv
module cpb_regs
    import cpb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [CNT_W-1:0]  last_cnt,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              clr_done,
    output logic [BUS_W-1:0]  bus_rdata
);

    reg_sel_e sel;
    logic     unused_hi;

    assign sel       = decode_offset(BUS_W'(bus_addr));
    assign cnt_wr    = bus_wr && (sel == SEL_COUNT);
    assign cnt_val   = bus_wdata[CNT_W-1:0];
    assign clr_done  = bus_wr && (sel == SEL_STATUS) && bus_wdata[ST_DONE_BIT];
    assign unused_hi = ^bus_wdata[BUS_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_COUNT:  bus_rdata <= BUS_W'(last_cnt);
                SEL_STATUS: bus_rdata <= status_word(busy, done);
                default:    bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cpb_engine.sv
module cpb_engine
    import cpb_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             clr_done,
    output logic             dclk,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] last_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    eng_flags_t       st;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            remain   <= '0;
            last_cnt <= '0;
        end else begin
            if (clr_done)
                st.done <= 1'b0;
            if (!st.busy) begin
                if (cnt_wr) begin
                    last_cnt <= cnt_val;
                    if (cnt_val == '0) begin
                        st.done <= 1'b1;
                    end else begin
                        st.busy <= 1'b1;
                        st.level <= 1'b1;
                        remain   <= cnt_val;
                    end
                end
            end else if (st.level) begin
                st.level <= 1'b0;
                remain   <= remain - ONE;
            end else if (remain == '0) begin
                st.busy <= 1'b0;
                st.done <= 1'b1;
            end else begin
                st.level <= 1'b1;
            end
        end
    end

    assign dclk = st.level;
    assign busy = st.busy;
    assign done = st.done;

endmodule

// File: rtl/cfg_pulse_burst.sv
module cfg_pulse_burst
    import cpb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dclk,
    output logic              busy
);

    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_val;
    logic             clr_done;
    logic             done_flag;
    logic [CNT_W-1:0] last_cnt;

    cpb_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done      (done_flag),
        .last_cnt  (last_cnt),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val),
        .clr_done  (clr_done),
        .bus_rdata (bus_rdata)
    );

    cpb_engine #(.CNT_W(CNT_W)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .cnt_wr   (cnt_wr),
        .cnt_val  (cnt_val),
        .clr_done (clr_done),
        .dclk     (dclk),
        .busy     (busy),
        .done     (done_flag),
        .last_cnt (last_cnt)
    );

endmodule

// File: rtl/cpb_checker.sv
module cpb_checker
    import cpb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              dclk,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  last_cnt
);

    logic count_hit;
    logic clear_hit;
    logic miss_rd;
    logic unused_wd;

    assign count_hit = bus_wr && (BUS_W'(bus_addr) == OFS_COUNT);
    assign clear_hit = bus_wr && (BUS_W'(bus_addr) == OFS_STATUS) && bus_wdata[0];
    assign miss_rd   = bus_rd && (BUS_W'(bus_addr) != OFS_COUNT) && (BUS_W'(bus_addr) != OFS_STATUS);
    assign unused_wd = ^bus_wdata[31:CNT_W];

    // R4
    dclk_needs_busy_chk: assert property (@(posedge clk) disable iff (rst) dclk |-> busy);

    // R4
    dclk_single_high_chk: assert property (@(posedge clk) disable iff (rst) dclk |=> !dclk);

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst) (done && !clear_hit) |=> done);

    // R6
    done_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_hit && !(busy && !dclk)) |=> !done);

    // R7
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (count_hit && !busy && (bus_wdata[CNT_W-1:0] == '0)) |=> (done && !busy));

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (count_hit && busy) |=> $stable(last_cnt));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        miss_rd |=> (bus_rdata == 32'h0));

endmodule

bind cfg_pulse_burst cpb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dclk      (dclk),
    .busy      (busy),
    .done      (done_flag),
    .last_cnt  (last_cnt)
);

// File: tb/cfg_pulse_burst_bench.sv
module cfg_pulse_burst_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int CNT_W      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              dclk;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int busy_cycles = 0;
    int shape_err = 0;
    logic prev_dclk = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    cfg_pulse_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg_pulse_burst (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dclk      (dclk),
        .busy      (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected read data one falling edge after the sampling edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    // Pulse shape and count observers
    always @(posedge dclk) pulses++;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cycles++;
            if ((dclk && prev_dclk) || (dclk && !busy)) shape_err++;
        end
        prev_dclk <= dclk;
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic start_counts();
        pulses = 0;
        busy_cycles = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 dclk", {31'b0, dclk}, 32'h0);
        check("R1 busy", {31'b0, busy}, 32'h0);
        bus_read(8'h0C, 32'h0, "R1 status");
        bus_read(8'h08, 32'h0, "R1 count");

        // R3 R4 R5 burst of 5
        start_counts();
        bus_write(8'h08, 32'd5);
        check("R3 busy after write", {31'b0, busy}, 32'h1);
        wait_idle();
        check("R4 pulse count", pulses, 32'd5);
        check("R3 busy length", busy_cycles, 32'd10);
        bus_read(8'h0C, 32'h1, "R5 done set");
        bus_read(8'h0C, 32'h1, "R5 done sticky");
        bus_read(8'h08, 32'd5, "R2 count readback");

        // R6 write-one-to-clear
        bus_write(8'h0C, 32'hFFFF_FFFE);
        bus_read(8'h0C, 32'h1, "R6 zero write keeps done");
        bus_write(8'h0C, 32'h1);
        bus_read(8'h0C, 32'h0, "R6 clear");

        // R7 zero count
        start_counts();
        bus_write(8'h08, 32'h0);
        check("R7 busy stays low", {31'b0, busy}, 32'h0);
        bus_read(8'h0C, 32'h1, "R7 done immediate");
        check("R7 no pulses", pulses, 32'd0);
        bus_write(8'h0C, 32'h1);

        // R2 R8 busy bit and ignored write
        start_counts();
        bus_write(8'h08, 32'd4);
        bus_read(8'h0C, 32'h2, "R2 busy bit");
        bus_write(8'h08, 32'd100);
        wait_idle();
        check("R8 pulse count", pulses, 32'd4);
        check("R8 busy length", busy_cycles, 32'd8);
        bus_read(8'h08, 32'd4, "R8 count unchanged");
        bus_write(8'h0C, 32'h1);

        // R9 unmapped
        bus_read(8'h00, 32'h0, "R9 read 0x00");
        bus_read(8'h04, 32'h0, "R9 read 0x04");
        bus_read(8'h10, 32'h0, "R9 read 0x10");
        start_counts();
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'd5);
        check("R9 no burst", {31'b0, busy}, 32'h0);
        bus_read(8'h08, 32'd4, "R9 count kept");
        bus_read(8'h0C, 32'h0, "R9 status kept");
        check("R9 no pulses", pulses, 32'd0);

        // R10 truncation and long burst
        start_counts();
        bus_write(8'h08, 32'h0001_07FF);
        wait_idle();
        check("R10 pulse count", pulses, 32'd2047);
        check("R10 busy length", busy_cycles, 32'd4094);
        bus_read(8'h08, 32'h7FF, "R10 count low bits");
        bus_read(8'h0C, 32'h1, "R5 done after long burst");

        check("R4 pulse shape", shape_err, 32'd0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule